// File: doc/BRIEF.md
# Field-Synchronous Capture Address Generator

This block produces the memory write address for every data word that an interlaced video capture path stores. Software programs three base addresses (odd-field video, even-field video and VBI data) and a line pitch through a small register port. The parity and VBI selection seen at the start of each field decide which base that field is written from. Each stored word moves the address on by four bytes. Each line start moves the line origin on by the pitch.

Base-address writes never disturb a field that is already being captured. A write lands in a shadow copy and raises a shared "base not yet applied" flag. The first word stored after the next field start copies all three shadows into the live registers in the same cycle and clears the flag. The block also counts lines within the field and pulses an interrupt on the first line that matches a programmed target.

Top module: `vcap_addr_gen`

## Requirements
- R1: After reset, every register reads zero: the status, the line count, the target, the three bases and the pitch. The not-applied flag is clear and the run bit is 0.
- R2: Writing a base register raises the not-applied flag (status bit 1). A readback of that base still returns the live value, which is unchanged until the next commit.
- R3: The first word stored after a field start copies all three shadow bases into the live registers at once and clears the not-applied flag. That word's address is already formed from the new value.
- R4: Base addresses are stored with bits [3:0] forced to zero, and the pitch with bits [1:0] forced to zero. This applies both to readback and to address generation.
- R5: The first word of a field is written at the selected base. The selection is made at field start: if field_vbi is 1, the VBI base is used; otherwise field_odd=1 selects the odd-video base and field_odd=0 selects the even-video base.
- R6: Within a line, each accepted data_valid produces wr_valid one cycle later. Each successive word address is 4 greater than the one before it.
- R7: Each line_start adds the pitch to the line origin and restarts the word offset. Word k of line n (n counted from 0) is therefore at base + n*pitch + 4*k.
- R8: The line counter is read at register 1. It is 0 after a field start, rises by 1 on each line_start, and holds at 1023.
- R9: line_irq is a one-cycle pulse, one cycle after the field_start or line_start that first makes the line counter equal to the target within a field. With target 0, the pulse follows the field start.
- R10: Run status (status bit 0) becomes 1 on a field start while cap_en is 1, and drops to 0 one cycle after cap_en goes low. While it is 0, data_valid produces no wr_valid.
- R11: The register map gives offsets 0 status, 1 line count (both read-only, writes ignored), 2 line target, 3 odd-video base, 4 even-video base, 5 VBI base and 6 pitch. reg_rdata is registered, one cycle after reg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| cap_en | input | 1 | Capture enable |
| field_start | input | 1 | One-cycle strobe at the start of a field |
| field_odd | input | 1 | Field parity, sampled with field_start |
| field_vbi | input | 1 | VBI field select, sampled with field_start |
| line_start | input | 1 | One-cycle strobe at each new line |
| data_valid | input | 1 | One word is being stored |
| wr_addr | output | 32 | Write byte address of the stored word |
| wr_valid | output | 1 | wr_addr is valid this cycle |
| run_status | output | 1 | Capture in progress |
| line_irq | output | 1 | Target-line interrupt pulse |

## Verification
The assertions assume that the strobes behave like video timing. field_start, line_start and data_valid never share a cycle, and a base write never lands in the same cycle as a commit. The single-pulse interrupt property also assumes that a field start does not directly follow the interrupt. The stimulus drives every strobe for exactly one cycle, with idle cycles between them. Register writes are issued only between fields, so every assumed input ordering holds throughout the sweep over field types, lines and words.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  typedef enum logic [2:0] {
    RA_STAT  = 3'd0,
    RA_LINE  = 3'd1,
    RA_TGT   = 3'd2,
    RA_ODD   = 3'd3,
    RA_EVEN  = 3'd4,
    RA_VBI   = 3'd5,
    RA_PITCH = 3'd6
  } reg_addr_e;

  localparam int NBASE = 3;

  typedef enum logic [1:0] {
    SEL_ODD  = 2'd0,
    SEL_EVEN = 2'd1,
    SEL_VBI  = 2'd2
  } base_sel_e;
endpackage

// File: rtl/vcap_regs.sv
module vcap_regs
  import vcap_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [2:0]                addr,
  input  logic [AW-1:0]             wdata,
  input  logic                      commit,
  input  logic                      running,
  input  logic [LW-1:0]             line_cnt,
  output logic [NBASE-1:0][AW-1:0]  act_base,
  output logic [NBASE-1:0][AW-1:0]  pend_base,
  output logic [AW-1:0]             pitch,
  output logic [LW-1:0]             target,
  output logic                      not_upd,
  output logic [AW-1:0]             rdata
);
  logic [NBASE-1:0] hit;
  logic             any_hit;

  for (genvar i = 0; i < NBASE; i++) begin : g_base
    assign hit[i] = we && (addr == 3'(int'(RA_ODD) + i));
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_base[i] <= '0;
        act_base[i]  <= '0;
      end else begin
        if (hit[i])  pend_base[i] <= {wdata[AW-1:4], 4'b0000};
        if (commit)  act_base[i]  <= pend_base[i];
      end
    end
  end

  assign any_hit = |hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      not_upd <= 1'b0;
      pitch   <= '0;
      target  <= '0;
      rdata   <= '0;
    end else begin
      if (any_hit)     not_upd <= 1'b1;
      else if (commit) not_upd <= 1'b0;
      if (we && addr == RA_PITCH) pitch  <= {wdata[AW-1:2], 2'b00};
      if (we && addr == RA_TGT)   target <= wdata[LW-1:0];
      case (addr)
        RA_STAT:  rdata <= AW'({not_upd, running});
        RA_LINE:  rdata <= AW'(line_cnt);
        RA_TGT:   rdata <= AW'(target);
        RA_ODD:   rdata <= act_base[SEL_ODD];
        RA_EVEN:  rdata <= act_base[SEL_EVEN];
        RA_VBI:   rdata <= act_base[SEL_VBI];
        RA_PITCH: rdata <= pitch;
        default:  rdata <= '0;
      endcase
    end
  end

  // R2
  wr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    any_hit |=> not_upd);

  // R3
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(act_base));

  // R3
  commit_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && !any_hit) |=> !not_upd);
endmodule

// File: rtl/vcap_line_track.sv
module vcap_line_track #(
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          field_start,
  input  logic          line_start,
  input  logic [LW-1:0] target,
  output logic [LW-1:0] line_cnt,
  output logic          line_irq
);
  localparam logic [LW-1:0] CNT_MAX = {LW{1'b1}};

  logic          armed;
  logic [LW-1:0] cnt_inc;

  assign cnt_inc = (line_cnt == CNT_MAX) ? line_cnt : line_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_cnt <= '0;
      armed    <= 1'b0;
      line_irq <= 1'b0;
    end else begin
      line_irq <= 1'b0;
      if (field_start) begin
        line_cnt <= '0;
        if (target == '0) begin
          line_irq <= 1'b1;
          armed    <= 1'b0;
        end else begin
          armed    <= 1'b1;
        end
      end else if (line_start) begin
        line_cnt <= cnt_inc;
        if (armed && cnt_inc == target) begin
          line_irq <= 1'b1;
          armed    <= 1'b0;
        end
      end
    end
  end

  // R8
  fs_zero_chk: assert property (@(posedge clk) disable iff (rst)
    field_start |=> (line_cnt == '0));

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (line_irq && !field_start) |=> !line_irq);
endmodule

// File: rtl/vcap_addr_calc.sv
module vcap_addr_calc
  import vcap_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cap_en,
  input  logic                      field_start,
  input  logic                      field_odd,
  input  logic                      field_vbi,
  input  logic                      line_start,
  input  logic                      data_valid,
  input  logic [NBASE-1:0][AW-1:0]  act_base,
  input  logic [NBASE-1:0][AW-1:0]  pend_base,
  input  logic [AW-1:0]             pitch,
  output logic                      running,
  output logic                      commit,
  output logic [AW-1:0]             wr_addr,
  output logic                      wr_valid
);
  localparam logic [AW-1:0] WORD_BYTES = AW'(4);

  base_sel_e     sel;
  logic          fresh;
  logic          store;
  logic [AW-1:0] line_off;
  logic [AW-1:0] word_off;
  logic [AW-1:0] base_use;

  assign store    = running && data_valid;
  assign commit   = store && fresh;
  assign base_use = fresh ? pend_base[sel] : act_base[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      sel      <= SEL_ODD;
      fresh    <= 1'b0;
      line_off <= '0;
      word_off <= '0;
      wr_addr  <= '0;
      wr_valid <= 1'b0;
    end else begin
      running  <= cap_en && (running || field_start);
      wr_valid <= store;
      if (store) begin
        wr_addr  <= base_use + line_off + word_off;
        word_off <= word_off + WORD_BYTES;
        fresh    <= 1'b0;
      end
      if (field_start) begin
        sel      <= field_vbi ? SEL_VBI : (field_odd ? SEL_ODD : SEL_EVEN);
        fresh    <= 1'b1;
        line_off <= '0;
        word_off <= '0;
      end else if (line_start) begin
        line_off <= line_off + pitch;
        word_off <= '0;
      end
    end
  end

  // R6
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_addr[1:0] == 2'b00));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !running |=> !wr_valid);

  // R3
  commit_once_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && !field_start) |=> !commit);
endmodule

// File: rtl/vcap_addr_gen.sv
module vcap_addr_gen
  import vcap_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          cap_en,
  input  logic          field_start,
  input  logic          field_odd,
  input  logic          field_vbi,
  input  logic          line_start,
  input  logic          data_valid,
  output logic [AW-1:0] wr_addr,
  output logic          wr_valid,
  output logic          run_status,
  output logic          line_irq
);
  logic [NBASE-1:0][AW-1:0] act_base;
  logic [NBASE-1:0][AW-1:0] pend_base;
  logic [AW-1:0]            pitch;
  logic [LW-1:0]            target;
  logic [LW-1:0]            line_cnt;
  logic                     not_upd;
  logic                     commit;
  logic                     running;

  vcap_regs #(.AW(AW), .LW(LW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .commit(commit), .running(running), .line_cnt(line_cnt),
    .act_base(act_base), .pend_base(pend_base), .pitch(pitch),
    .target(target), .not_upd(not_upd), .rdata(reg_rdata)
  );

  vcap_line_track #(.LW(LW)) u_line (
    .clk(clk), .rst(rst), .field_start(field_start), .line_start(line_start),
    .target(target), .line_cnt(line_cnt), .line_irq(line_irq)
  );

  vcap_addr_calc #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .cap_en(cap_en), .field_start(field_start),
    .field_odd(field_odd), .field_vbi(field_vbi), .line_start(line_start),
    .data_valid(data_valid), .act_base(act_base), .pend_base(pend_base),
    .pitch(pitch), .running(running), .commit(commit),
    .wr_addr(wr_addr), .wr_valid(wr_valid)
  );

  assign run_status = running;

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!not_upd && !running && line_cnt == '0));
endmodule

// File: tb/vcap_addr_gen_test.sv
module vcap_addr_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PITCH_W = 32'h0000_0103;
  localparam logic [31:0] PITCH_E = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cap_en = 1'b0;
  logic        field_start = 1'b0;
  logic        field_odd = 1'b0;
  logic        field_vbi = 1'b0;
  logic        line_start = 1'b0;
  logic        data_valid = 1'b0;
  logic [31:0] wr_addr;
  logic        wr_valid;
  logic        run_status;
  logic        line_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] live [3];

  vcap_addr_gen uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_en(cap_en),
    .field_start(field_start), .field_odd(field_odd), .field_vbi(field_vbi),
    .line_start(line_start), .data_valid(data_valid), .wr_addr(wr_addr),
    .wr_valid(wr_valid), .run_status(run_status), .line_irq(line_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rreg(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk); reg_addr = a;
    @(negedge clk); chk(tag, reg_rdata, exp);
  endtask

  task automatic fstart(logic odd, logic vbi, logic exp_irq);
    @(negedge clk); field_start = 1'b1; field_odd = odd; field_vbi = vbi;
    @(negedge clk); field_start = 1'b0;
    chk("R9 irq after field start", 32'(line_irq), 32'(exp_irq));
    @(negedge clk);
    chk("R9 irq single cycle", 32'(line_irq), 32'd0);
  endtask

  task automatic lstart(logic exp_irq);
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    chk("R9 irq after line start", 32'(line_irq), 32'(exp_irq));
    @(negedge clk);
    chk("R9 irq single cycle", 32'(line_irq), 32'd0);
  endtask

  task automatic store(logic [31:0] exp, string tag);
    @(negedge clk); data_valid = 1'b1;
    @(negedge clk); data_valid = 1'b0;
    chk({tag, " valid"}, 32'(wr_valid), 32'd1);
    chk({tag, " addr"}, wr_addr, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 7; a++) rreg(3'(a), 32'd0, "R1 reset readback");
    for (int b = 0; b < 3; b++) live[b] = '0;

    // R11: writes to read-only offsets are ignored
    wreg(3'd1, 32'h0000_03FF);
    rreg(3'd1, 32'd0, "R11 line count read-only");
    wreg(3'd6, PITCH_W);
    rreg(3'd6, PITCH_E, "R4 pitch low bits cleared");
    cap_en = 1'b1;

    for (int m = 0; m < 3; m++) begin
      logic [31:0] nb [3];
      logic [31:0] tgt;
      int sel;
      tgt = (m == 1) ? 32'd0 : 32'd3;
      wreg(3'd2, tgt);
      rreg(3'd2, tgt, "R11 target readback");
      for (int b = 0; b < 3; b++) begin
        nb[b] = 32'h1000_0000 * (b + 1) + 32'h0001_0000 * m + 32'h0000_0017;
        wreg(3'(3 + b), nb[b]);
        nb[b] = nb[b] & 32'hFFFF_FFF0;
      end
      rreg(3'd0, {30'd0, 1'b1, (m != 0)}, "R2 flag set after base write");
      for (int b = 0; b < 3; b++) rreg(3'(3 + b), live[b], "R2 live base unchanged");
      sel = (m == 2) ? 2 : ((m == 0) ? 0 : 1);
      fstart(m != 1, m == 2, m == 1);
      rreg(3'd0, 32'd3, "R10 run set with flag");
      rreg(3'd1, 32'd0, "R8 line zero at field start");
      rreg(3'(3 + sel), live[sel], "R2 still old before first store");
      for (int l = 0; l < 5; l++) begin
        if (l > 0) lstart(tgt == 32'(l));
        for (int k = 0; k < 3; k++)
          store(nb[sel] + PITCH_E * l + 4 * k, (l == 0 && k == 0) ? "R5 first store" : "R7 R6 word");
        if (l == 0) begin
          for (int b = 0; b < 3; b++) live[b] = nb[b];
          rreg(3'd0, 32'd1, "R3 flag cleared by commit");
          for (int b = 0; b < 3; b++) rreg(3'(3 + b), live[b], "R3 R4 committed base");
        end
      end
      rreg(3'd1, 32'd4, "R8 line count after four starts");
    end

    // R8 saturation at 1023
    fstart(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 1030; i++) begin
      @(negedge clk); line_start = 1'b1;
      @(negedge clk); line_start = 1'b0;
    end
    rreg(3'd1, 32'd1023, "R8 counter saturates");

    // R10 drop of enable
    @(negedge clk); cap_en = 1'b0;
    @(negedge clk);
    chk("R10 run status low", 32'(run_status), 32'd0);
    @(negedge clk); data_valid = 1'b1;
    @(negedge clk); data_valid = 1'b0;
    chk("R10 no store when idle", 32'(wr_valid), 32'd0);
    rreg(3'd0, 32'd0, "R10 status idle");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule